// File: doc/BRIEF.md
# DMA Channel Start and Completion Interrupt Registers

This block is the register front end of a small multi-channel DMA controller together with the system interrupt status word it feeds. Software programs a per-channel address word, block word and control word over a simple 32-bit register port. It also programs one global channel-enable word and one DMA interrupt control word. When a channel's control word is written with its go bit set, the block sends a one-cycle start pulse to the transfer engine. The pulse is sent only if that channel is enabled in the global enable word at that moment.

The transfer engine reports the end of a transfer with a one-cycle done pulse for each channel. On that pulse the block clears the channel's go bit. If the channel's interrupt enable is set, the block also raises the channel's completion flag and sets the DMA bit of the system interrupt status word. Software acknowledges the completion flags by writing ones to them. It acknowledges the status word by writing zeros, filtered through a mask word. A level interrupt output reflects any unmasked status bit.

Channel n (0..6) owns three words at byte offsets 0x080 + 0x10·n: address at +0x0, block at +0x4 and control at +0x8. The remaining words sit at these offsets: status at 0x070, mask at 0x074, global enable at 0x0F0 and DMA interrupt control at 0x0F4.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset every register reads zero, start_o is all zero and sys_irq_o is low.
- R2: The address, block and control words of every channel, the global enable word (0x0F0) and the mask word (0x074) read back the last value written to them.
- R3: A write to channel n's control word with bit 24 set, while bit 3+4·n of the global enable word is set, drives start_o[n] high for exactly the one cycle after the write. Without both conditions start_o stays low.
- R4: A done pulse on channel n clears bit 24 of that channel's control word and leaves its other bits unchanged. A control write in the same cycle takes precedence.
- R5: A done pulse on channel n sets bit 24+n of the DMA interrupt control word when bit 16+n of that word is set. Otherwise the flag is left unchanged.
- R6: When a completion flag is raised, bit 3 of the status word is set in the same cycle.
- R7: A write to the DMA interrupt control word stores bits 0..23 from the data. In bits 24..31, each written 1 clears the bit and each written 0 keeps it.
- R8: A write to the status word leaves it equal to old status AND mask AND written data.
- R9: When a completion flag set and a software clear of the same bit fall in one cycle, the bit ends up set. This holds for both the interrupt control flag and status bit 3.
- R10: Reads of unmapped or non-word-aligned offsets return zero.
- R11: sys_irq_o is high exactly when some status bit is set whose mask bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| done_i | input | NUM_CH | Per-channel transfer completion pulse |
| start_o | output | NUM_CH | Per-channel transfer start pulse |
| sys_irq_o | output | 1 | System interrupt, unmasked status pending |

## Verification
The two functions that can collide are a hardware completion and a software acknowledge of the same bit. Both write the interrupt control flags and both touch status bit 3. The bench drives a done pulse on the exact cycle that software writes a 1 to the matching flag bit, and checks that the flag still reads 1 afterwards. In a separate case it pairs a done pulse with a status write of zero and expects bit 3 and sys_irq_o to stay set. A second overlap, a control write arriving with a done pulse, is judged by reading back that the newly written go bit survives.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned ADDR_W       = 12;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned MAX_CH       = 7;
  localparam int unsigned CH_STRIDE    = 16;
  localparam int unsigned GO_BIT       = 24;
  localparam int unsigned IEN_BASE     = 16;
  localparam int unsigned FLAG_BASE    = 24;
  localparam int unsigned STAT_DMA_BIT = 3;

  localparam logic [ADDR_W-1:0] OFS_STAT    = 12'h070;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 12'h074;
  localparam logic [ADDR_W-1:0] OFS_CH_BASE = 12'h080;
  localparam logic [ADDR_W-1:0] OFS_GEN     = 12'h0F0;
  localparam logic [ADDR_W-1:0] OFS_ICR     = 12'h0F4;

  typedef enum int unsigned {CR_ADDR = 0, CR_BLK = 1, CR_CTRL = 2} chan_reg_e;

  function automatic int unsigned en_bit(int unsigned n);
    return 3 + 4 * n;
  endfunction

  function automatic logic [ADDR_W-1:0] ch_ofs(int unsigned n, chan_reg_e r);
    return ADDR_W'(32'(OFS_CH_BASE) + n * CH_STRIDE + 4 * 32'(r));
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_addr_i,
  input  logic              wr_blk_i,
  input  logic              wr_ctrl_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              chan_en_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] madr_o,
  output logic [DATA_W-1:0] bcr_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              start_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      madr_o  <= '0;
      bcr_o   <= '0;
      ctrl_o  <= '0;
      start_o <= 1'b0;
    end else begin
      if (wr_addr_i) madr_o <= wdata_i;
      if (wr_blk_i)  bcr_o  <= wdata_i;
      // software write wins over completion
      if (wr_ctrl_i)   ctrl_o         <= wdata_i;
      else if (done_i) ctrl_o[GO_BIT] <= 1'b0;
      start_o <= wr_ctrl_i & wdata_i[GO_BIT] & chan_en_i;
    end
  end

  // R3
  start_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ($past(chan_en_i) && ctrl_o[GO_BIT]));
  // R4
  go_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !wr_ctrl_i) |=> (!ctrl_o[GO_BIT] && ctrl_o[GO_BIT-1:0] == $past(ctrl_o[GO_BIT-1:0])));

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_icr_i,
  input  logic              wr_stat_i,
  input  logic              wr_mask_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic [DATA_W-1:0] icr_o,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] mask_o
);

  localparam int unsigned FLAG_W = DATA_W - FLAG_BASE;

  logic [NUM_CH-1:0] set_v;
  logic [DATA_W-1:0] icr_d, stat_d;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_set
    assign set_v[n] = done_i[n] & icr_o[IEN_BASE+n];
  end

  always_comb begin
    icr_d = icr_o;
    if (wr_icr_i)
      icr_d = {icr_o[DATA_W-1:FLAG_BASE] & ~wdata_i[DATA_W-1:FLAG_BASE],
               wdata_i[FLAG_BASE-1:0]};
    // set wins over clear
    for (int n = 0; n < NUM_CH; n++)
      if (set_v[n]) icr_d[FLAG_BASE+n] = 1'b1;
    stat_d = wr_stat_i ? (stat_o & mask_o & wdata_i) : stat_o;
    if (|set_v) stat_d[STAT_DMA_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icr_o  <= '0;
      stat_o <= '0;
      mask_o <= '0;
    end else begin
      icr_o  <= icr_d;
      stat_o <= stat_d;
      if (wr_mask_i) mask_o <= wdata_i;
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    // R5
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_v[n] |=> icr_o[FLAG_BASE+n]);
  end
  // R6
  stat_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_v) |=> stat_o[STAT_DMA_BIT]);
  // R8
  stat_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|set_v) |=> ((stat_o & ~$past(stat_o)) == '0));
  // R7
  flag_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|set_v) |=> ((icr_o[DATA_W-1:FLAG_BASE] & ~$past(icr_o[DATA_W-1:FLAG_BASE])) == FLAG_W'(0)));

endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] done_i,
  output logic [NUM_CH-1:0] start_o,
  output logic              sys_irq_o
);

  logic [DATA_W-1:0] gen_q, icr, stat, mask;
  logic [NUM_CH-1:0][DATA_W-1:0] madr, bcr, ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gen_q <= '0;
    else if (we_i && addr_i == OFS_GEN) gen_q <= wdata_i;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    dma_chan_regs u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_addr_i (we_i && addr_i == ch_ofs(n, CR_ADDR)),
      .wr_blk_i  (we_i && addr_i == ch_ofs(n, CR_BLK)),
      .wr_ctrl_i (we_i && addr_i == ch_ofs(n, CR_CTRL)),
      .wdata_i   (wdata_i),
      .chan_en_i (gen_q[en_bit(n)]),
      .done_i    (done_i[n]),
      .madr_o    (madr[n]),
      .bcr_o     (bcr[n]),
      .ctrl_o    (ctrl[n]),
      .start_o   (start_o[n])
    );
  end

  dma_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_icr_i  (we_i && addr_i == OFS_ICR),
    .wr_stat_i (we_i && addr_i == OFS_STAT),
    .wr_mask_i (we_i && addr_i == OFS_MASK),
    .wdata_i   (wdata_i),
    .done_i    (done_i),
    .icr_o     (icr),
    .stat_o    (stat),
    .mask_o    (mask)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_STAT: rdata_o = stat;
      OFS_MASK: rdata_o = mask;
      OFS_GEN:  rdata_o = gen_q;
      OFS_ICR:  rdata_o = icr;
      default: ;
    endcase
    for (int n = 0; n < NUM_CH; n++) begin
      if (addr_i == ch_ofs(n, CR_ADDR)) rdata_o = madr[n];
      if (addr_i == ch_ofs(n, CR_BLK))  rdata_o = bcr[n];
      if (addr_i == ch_ofs(n, CR_CTRL)) rdata_o = ctrl[n];
    end
  end

  assign sys_irq_o = |(stat & mask);

  // R3
  start_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o != '0 |-> $past(we_i) && $past(wdata_i[GO_BIT]));
  // R11
  irq_needs_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_irq_o |-> (stat != '0 && mask != '0));

endmodule

// File: tb/dma_irq_regs_tb_top.sv
`timescale 1ns/1ps
module dma_irq_regs_tb_top;
  localparam int NCH = 7;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] done = '0, start;
  logic sys_irq;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  dma_irq_regs #(.NUM_CH(NCH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .done_i(done), .start_o(start), .sys_irq_o(sys_irq)
  );

  function automatic logic [11:0] cofs(int n, int r);
    return 12'(12'h080 + n * 16 + 4 * r);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic pulse(int n);
    @(negedge clk); done = NCH'(1) << n;
    @(negedge clk); done = '0;
  endtask

  logic [31:0] v;

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    foreach (v[i]) ;
    for (int n = 0; n < NCH; n++)
      for (int r = 0; r < 3; r++) begin rd(cofs(n, r), v); chk("R1 chan", v, 0); end
    rd(12'h070, v); chk("R1 stat", v, 0);
    rd(12'h074, v); chk("R1 mask", v, 0);
    rd(12'h0F0, v); chk("R1 gen", v, 0);
    rd(12'h0F4, v); chk("R1 icr", v, 0);
    chk("R1 start", 32'(start), 0);
    chk("R1 irq", 32'(sys_irq), 0);

    // R2
    for (int n = 0; n < NCH; n++) begin
      wr(cofs(n, 0), 32'h1000_0000 + n * 32'h111);
      wr(cofs(n, 1), ~(32'h1000_0000 + n * 32'h111));
    end
    for (int n = 0; n < NCH; n++) begin
      rd(cofs(n, 0), v); chk("R2 addr", v, 32'h1000_0000 + n * 32'h111);
      rd(cofs(n, 1), v); chk("R2 blk", v, ~(32'h1000_0000 + n * 32'h111));
    end
    wr(12'h074, 32'h5A5A_0008); rd(12'h074, v); chk("R2 mask", v, 32'h5A5A_0008);

    // R3 sweep: channel x enable x go
    for (int n = 0; n < NCH; n++)
      for (int b = 0; b < 4; b++) begin
        logic [31:0] cv;
        cv = (b[1] ? 32'h0100_0000 : 0) | 32'(8'hA0 + n);
        wr(12'h0F0, b[0] ? (32'h1 << (3 + 4 * n)) : 32'hF7FF_FFF7 & ~(32'h1 << (3 + 4 * n)));
        rd(12'h0F0, v);
        chk("R2 gen", v, b[0] ? (32'h1 << (3 + 4 * n)) : 32'hF7FF_FFF7 & ~(32'h1 << (3 + 4 * n)));
        wr(cofs(n, 2), cv);
        chk("R3 start", 32'(start), (b == 3) ? (32'h1 << n) : 0);
        @(negedge clk);
        chk("R3 one cycle", 32'(start), 0);
        rd(cofs(n, 2), v); chk("R2 ctrl", v, cv);
      end

    // R4 R5 R6 R11 per channel, interrupt enable on/off
    wr(12'h074, 32'h0000_0008);
    for (int n = 0; n < NCH; n++)
      for (int ie = 0; ie < 2; ie++) begin
        logic [31:0] lo;
        lo = (ie != 0 ? (32'h1 << (16 + n)) : 0) | 32'h0000_0C3;
        wr(12'h0F4, 32'hFF00_0000 | lo);
        wr(12'h070, 32'h0);
        wr(cofs(n, 2), 32'h0100_0033);
        pulse(n);
        rd(cofs(n, 2), v); chk("R4 go cleared", v, 32'h0000_0033);
        rd(12'h0F4, v); chk("R5 flag", v, lo | (ie != 0 ? (32'h1 << (24 + n)) : 0));
        rd(12'h070, v); chk("R6 stat", v, ie != 0 ? 32'h8 : 0);
        chk("R11 irq", 32'(sys_irq), 32'(ie));
      end

    // R7: flags of ch6 set now
    wr(12'h0F4, 32'h00AB_CDEF);
    rd(12'h0F4, v); chk("R7 low store flag keep", v, 32'h40AB_CDEF);
    wr(12'h0F4, 32'hBF12_3456);
    rd(12'h0F4, v); chk("R7 w0 keeps", v, 32'h4012_3456);
    wr(12'h0F4, 32'h4000_0000);
    rd(12'h0F4, v); chk("R7 w1 clears", v, 32'h0);

    // R8 R11: stat=8 from earlier
    wr(12'h070, 32'hFFFF_FFFF);
    rd(12'h070, v); chk("R8 ack keep", v, 32'h8);
    wr(12'h074, 32'h0);
    chk("R11 masked", 32'(sys_irq), 0);
    wr(12'h070, 32'hFFFF_FFFF);
    rd(12'h070, v); chk("R8 mask zero", v, 32'h0);
    wr(12'h074, 32'h0000_0008);

    // R9 collisions
    for (int n = 0; n < NCH; n++) begin
      wr(12'h0F4, 32'hFF00_0000 | (32'h1 << (16 + n)));
      @(negedge clk);
      we = 1'b1; addr = 12'h0F4; wdata = (32'h1 << (24 + n)) | (32'h1 << (16 + n));
      done = NCH'(1) << n;
      @(negedge clk); we = 1'b0; done = '0;
      rd(12'h0F4, v); chk("R9 flag set wins", v, (32'h1 << (24 + n)) | (32'h1 << (16 + n)));
      @(negedge clk);
      we = 1'b1; addr = 12'h070; wdata = 32'h0; done = NCH'(1) << n;
      @(negedge clk); we = 1'b0; done = '0;
      rd(12'h070, v); chk("R9 stat set wins", v, 32'h8);
      chk("R11 irq", 32'(sys_irq), 1);
      // R4 control write beats done
      @(negedge clk);
      we = 1'b1; addr = cofs(n, 2); wdata = 32'h0100_0011; done = NCH'(1) << n;
      @(negedge clk); we = 1'b0; done = '0;
      rd(cofs(n, 2), v); chk("R4 write wins", v, 32'h0100_0011);
    end

    // R10
    rd(12'h000, v); chk("R10 unmapped", v, 0);
    rd(12'h071, v); chk("R10 unaligned", v, 0);
    rd(12'h0FC, v); chk("R10 unmapped", v, 0);
    rd(12'h08C, v); chk("R10 chan gap", v, 0);
    rd(12'h0F6, v); chk("R10 unaligned", v, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule